// File: doc/BRIEF.md
# DRAM Rank Low-Power State Controller

This block owns the clock-enable driven sleep state of one DRAM rank. It watches an idle indication from the scheduler and a flag that says whether any bank still holds an open row. After a programmable run of idle cycles it puts the rank to sleep: active power-down if a row is open, otherwise one of three precharge power-down flavours picked by two policy bits. A second, longer idle threshold moves a precharged rank on into self-refresh, optionally with the register PLL switched off as well.

A wake request starts the exit. The controller raises CKE and then counts out the exit latency that belongs to the state being left. While that count runs, ready stays low and further wake requests are ignored. The count runs from a few cycles for the fast power-downs up to the 512-cycle DLL relock, plus about 6 µs of PLL relock for the register-off self-refresh. Ready returns in the cycle the count ends. The current state is always available as an encoded output, so a residency counter outside the block can track how long the rank spends in each state.

States: PRE_STBY (0), ACT_STBY (1), ACT_PD (2), PD_FAST (3), PD_SLOW (4), PD_SLOW_RO (5), SR (6), SR_RO (7), EXIT (8). Transitions: standby-follow (between the two standby states), pd-enter (standby to 2..5), sr-enter (3..5 to 6/7), wake (2..7 to EXIT) and exit-done (EXIT to a standby state).

Top module: `dram_lp_ctrl`

## Requirements
- R1: After reset state_o is 0 (PRE_STBY). In standby, cke_o and ready_o are 1, and each cycle state_o follows bank_open_i: 1 (ACT_STBY) when it is high, 0 (PRE_STBY) when it is low.
- R2: A standby cycle counts as idle only when idle_i=1 and wake_i=0. Any other standby cycle clears the count. The rank leaves standby at the edge where the consecutive idle count reaches pd_idle_lim_i; a limit of 0 behaves like 1.
- R3: The power-down entered is chosen at the entry edge. It is 2 (ACT_PD) if bank_open_i=1. Otherwise it is 3 (PD_FAST) if dll_stop_i=0, 4 (PD_SLOW) if dll_stop_i=1 and reg_off_i=0, and 5 (PD_SLOW_RO) if both are 1.
- R4: From states 3, 4 or 5, when no wake is pending, the rank enters self-refresh at the edge where the idle count reaches sr_idle_lim_i. The count runs on every sleeping cycle and continues from the standby run. It enters 7 (SR_RO) if reg_off_i=1 at that edge, otherwise 6 (SR). ACT_PD never enters self-refresh.
- R5: In states 2 to 7, cke_o=0 and ready_o=0. ready_o is 1 only in the standby states.
- R6: dll_off_o=1 exactly in states 4, 5, 6 and 7. term_off_o=1 exactly in states 5 and 7. pll_off_o=1 only in state 7.
- R7: wake_i=1 in states 2 to 7 moves the rank to 8 (EXIT) at the next edge. In EXIT, cke_o=1, ready_o=0, and dll_off_o, term_off_o and pll_off_o are 0.
- R8: ready_o rises exactly L clock edges after the edge that sampled the wake, and the rank then enters the standby state chosen by bank_open_i. L is XP_CYC for states 2 and 3, XPDLL_CYC for 4, MRD_CYC+XPDLL_CYC for 5, SR_EXIT_CYC for 6 and SR_EXIT_CYC+PLL_RELOCK_CYC for 7.
- R9: wake_i during EXIT has no effect on the countdown or on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_i | input | 1 | Scheduler has nothing pending for this rank |
| bank_open_i | input | 1 | At least one bank holds an open row |
| dll_stop_i | input | 1 | Policy: stop the DLL in precharge power-down |
| reg_off_i | input | 1 | Policy: use the register-off variants |
| wake_i | input | 1 | Request to bring the rank back to standby |
| pd_idle_lim_i | input | CNT_W | Idle cycles before power-down |
| sr_idle_lim_i | input | CNT_W | Idle cycles before self-refresh |
| cke_o | output | 1 | Clock enable to the rank |
| dll_off_o | output | 1 | DLL stopped |
| term_off_o | output | 1 | Input termination and output ODT off |
| pll_off_o | output | 1 | Register PLL off |
| ready_o | output | 1 | Rank may accept a command |
| state_o | output | 4 | Encoded current state (0..8 as listed) |

## Verification
All outputs are decoded from the state register alone. A wrong next-state choice therefore shows on state_o and on the CKE, DLL, termination and PLL controls one edge after the input that caused it, and the reference model compares these on every cycle. A fault in the exit countdown only shows at the end of the exit, when ready_o rises early or late. For that reason the exit length of each of the six sleep states is measured edge by edge, once with wake pulses injected during the count.

// File: rtl/dram_lp_pkg.sv
`timescale 1ns/1ps
package dram_lp_pkg;

    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        LP_PRE_STBY   = 4'd0,
        LP_ACT_STBY   = 4'd1,
        LP_ACT_PD     = 4'd2,
        LP_PD_FAST    = 4'd3,
        LP_PD_SLOW    = 4'd4,
        LP_PD_SLOW_RO = 4'd5,
        LP_SR         = 4'd6,
        LP_SR_RO      = 4'd7,
        LP_EXIT       = 4'd8
    } lp_state_e;

    function automatic logic is_sleep(lp_state_e s);
        return (s == LP_ACT_PD) || (s == LP_PD_FAST) || (s == LP_PD_SLOW) ||
               (s == LP_PD_SLOW_RO) || (s == LP_SR) || (s == LP_SR_RO);
    endfunction

    function automatic logic is_standby(lp_state_e s);
        return (s == LP_PRE_STBY) || (s == LP_ACT_STBY);
    endfunction

endpackage

// File: rtl/dram_lp_idle_timer.sv
`timescale 1ns/1ps
// Saturating idle-cycle counter; exposes the value it would take on increment.
module dram_lp_idle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_nxt_o
);
    logic [CNT_W-1:0] cnt_q;

    assign cnt_nxt_o = (&cnt_q) ? cnt_q : cnt_q + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (inc_i) cnt_q <= cnt_nxt_o;
    end
endmodule

// File: rtl/dram_lp_exit_timer.sv
`timescale 1ns/1ps
// Exit countdown: load with a latency L (L >= 1); done is high in the last of L cycles.
module dram_lp_exit_timer #(
    parameter int LAT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LAT_W-1:0] load_val_i,
    output logic             done_o
);
    logic [LAT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= load_val_i - LAT_W'(1);
        else if (cnt_q != '0)    cnt_q <= cnt_q - LAT_W'(1);
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/dram_lp_ctrl.sv
`timescale 1ns/1ps
module dram_lp_ctrl
    import dram_lp_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int XP_CYC         = 3,
    parameter int XPDLL_CYC      = 10,
    parameter int MRD_CYC        = 4,
    parameter int SR_EXIT_CYC    = 512,
    parameter int PLL_RELOCK_CYC = 1500
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idle_i,
    input  logic               bank_open_i,
    input  logic               dll_stop_i,
    input  logic               reg_off_i,
    input  logic               wake_i,
    input  logic [CNT_W-1:0]   pd_idle_lim_i,
    input  logic [CNT_W-1:0]   sr_idle_lim_i,
    output logic               cke_o,
    output logic               dll_off_o,
    output logic               term_off_o,
    output logic               pll_off_o,
    output logic               ready_o,
    output logic [STATE_W-1:0] state_o
);
    localparam int LAT_RO  = MRD_CYC + XPDLL_CYC;
    localparam int LAT_SRR = SR_EXIT_CYC + PLL_RELOCK_CYC;
    localparam int MAX_LAT = (LAT_RO > LAT_SRR) ? LAT_RO : LAT_SRR;
    localparam int LAT_W   = $clog2(MAX_LAT + 1);

    lp_state_e        state_q, state_d;
    logic             idle_clr, idle_inc, exit_load, exit_done;
    logic [CNT_W-1:0] idle_nxt;
    logic [LAT_W-1:0] lat_sel;
    lp_state_e        stby_sel, pd_sel, sr_sel;

    dram_lp_idle_timer #(.CNT_W(CNT_W)) idle_tmr_i (
        .clk(clk), .rst_n(rst_n), .clr_i(idle_clr), .inc_i(idle_inc),
        .cnt_nxt_o(idle_nxt)
    );

    dram_lp_exit_timer #(.LAT_W(LAT_W)) exit_tmr_i (
        .clk(clk), .rst_n(rst_n), .load_i(exit_load), .load_val_i(lat_sel),
        .done_o(exit_done)
    );

    // Exit latency belonging to the state being left
    always_comb begin
        unique case (state_q)
            LP_ACT_PD, LP_PD_FAST: lat_sel = LAT_W'(XP_CYC);
            LP_PD_SLOW:            lat_sel = LAT_W'(XPDLL_CYC);
            LP_PD_SLOW_RO:         lat_sel = LAT_W'(LAT_RO);
            LP_SR:                 lat_sel = LAT_W'(SR_EXIT_CYC);
            LP_SR_RO:              lat_sel = LAT_W'(LAT_SRR);
            default:               lat_sel = LAT_W'(1);
        endcase
    end

    assign stby_sel = bank_open_i ? LP_ACT_STBY : LP_PRE_STBY;
    assign pd_sel   = bank_open_i ? LP_ACT_PD :
                      !dll_stop_i ? LP_PD_FAST :
                      reg_off_i   ? LP_PD_SLOW_RO : LP_PD_SLOW;
    assign sr_sel   = reg_off_i ? LP_SR_RO : LP_SR;

    // Next-state and timer control
    always_comb begin
        state_d   = state_q;
        idle_clr  = 1'b0;
        idle_inc  = 1'b0;
        exit_load = 1'b0;
        unique case (state_q)
            LP_PRE_STBY, LP_ACT_STBY: begin
                idle_inc = idle_i && !wake_i;
                idle_clr = !idle_inc;
                if (idle_inc && (idle_nxt >= pd_idle_lim_i)) state_d = pd_sel;
                else                                          state_d = stby_sel;
            end
            LP_ACT_PD, LP_SR, LP_SR_RO: begin
                if (wake_i) begin
                    state_d   = LP_EXIT;
                    exit_load = 1'b1;
                    idle_clr  = 1'b1;
                end else begin
                    idle_inc  = 1'b1;
                end
            end
            LP_PD_FAST, LP_PD_SLOW, LP_PD_SLOW_RO: begin
                if (wake_i) begin
                    state_d   = LP_EXIT;
                    exit_load = 1'b1;
                    idle_clr  = 1'b1;
                end else begin
                    idle_inc  = 1'b1;
                    if (idle_nxt >= sr_idle_lim_i) state_d = sr_sel;
                end
            end
            LP_EXIT: begin
                idle_clr = 1'b1;
                if (exit_done) state_d = stby_sel;
            end
            default: state_d = LP_PRE_STBY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LP_PRE_STBY;
        else        state_q <= state_d;
    end

    // Outputs decoded from the state register only
    always_comb begin
        cke_o      = 1'b0;
        dll_off_o  = 1'b0;
        term_off_o = 1'b0;
        pll_off_o  = 1'b0;
        ready_o    = 1'b0;
        unique case (state_q)
            LP_PRE_STBY, LP_ACT_STBY: begin
                cke_o   = 1'b1;
                ready_o = 1'b1;
            end
            LP_ACT_PD, LP_PD_FAST: ;
            LP_PD_SLOW, LP_SR:     dll_off_o = 1'b1;
            LP_PD_SLOW_RO: begin
                dll_off_o  = 1'b1;
                term_off_o = 1'b1;
            end
            LP_SR_RO: begin
                dll_off_o  = 1'b1;
                term_off_o = 1'b1;
                pll_off_o  = 1'b1;
            end
            LP_EXIT:               cke_o = 1'b1;
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/dram_lp_ctrl_chk.sv
`timescale 1ns/1ps
module dram_lp_ctrl_chk
    import dram_lp_pkg::*;
#(
    parameter int XP_CYC         = 3,
    parameter int XPDLL_CYC      = 10,
    parameter int MRD_CYC        = 4,
    parameter int SR_EXIT_CYC    = 512,
    parameter int PLL_RELOCK_CYC = 1500
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wake_i,
    input logic               bank_open_i,
    input logic               cke_o,
    input logic               dll_off_o,
    input logic               term_off_o,
    input logic               pll_off_o,
    input logic               ready_o,
    input logic [STATE_W-1:0] state_o
);
    lp_state_e st;
    int        exp_lat;
    int        ecnt;

    assign st = lp_state_e'(state_o);

    function automatic int lat_of(lp_state_e s);
        case (s)
            LP_ACT_PD, LP_PD_FAST: return XP_CYC;
            LP_PD_SLOW:            return XPDLL_CYC;
            LP_PD_SLOW_RO:         return MRD_CYC + XPDLL_CYC;
            LP_SR:                 return SR_EXIT_CYC;
            LP_SR_RO:              return SR_EXIT_CYC + PLL_RELOCK_CYC;
            default:               return 1;
        endcase
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_lat <= 1;
            ecnt    <= 0;
        end else begin
            if (is_sleep(st) && wake_i) exp_lat <= lat_of(st);
            ecnt <= (st == LP_EXIT) ? ecnt + 1 : 0;
        end
    end

    assert_sleep_cke_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_sleep(st) |-> (!cke_o && !ready_o));

    assert_ready_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (is_standby(st) && cke_o));

    assert_wake_to_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sleep(st) && wake_i) |=> (st == LP_EXIT));

    assert_exit_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != LP_EXIT) && ($past(st) == LP_EXIT)) |-> (ecnt == exp_lat));

    assert_exit_no_early_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == LP_EXIT) && (ecnt + 1 < exp_lat)) |=> (st == LP_EXIT));

    assert_act_pd_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == LP_ACT_PD) && ($past(st) != LP_ACT_PD)) |-> $past(bank_open_i));

    assert_no_sr_from_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == LP_ACT_PD) |-> ((st == LP_ACT_PD) || (st == LP_EXIT)));

    assert_fast_pd_dll_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LP_PD_FAST) |-> (!dll_off_o && !term_off_o && !pll_off_o));
endmodule

bind dram_lp_ctrl dram_lp_ctrl_chk #(
    .XP_CYC(XP_CYC), .XPDLL_CYC(XPDLL_CYC), .MRD_CYC(MRD_CYC),
    .SR_EXIT_CYC(SR_EXIT_CYC), .PLL_RELOCK_CYC(PLL_RELOCK_CYC)
) chk_i (
    .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .bank_open_i(bank_open_i),
    .cke_o(cke_o), .dll_off_o(dll_off_o), .term_off_o(term_off_o),
    .pll_off_o(pll_off_o), .ready_o(ready_o), .state_o(state_o)
);

// File: tb/dram_lp_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_lp_ctrl_tb_top;
    localparam int CNT_W  = 16;
    localparam int T_XP   = 3;
    localparam int T_XPD  = 10;
    localparam int T_MRD  = 4;
    localparam int T_SR   = 512;
    localparam int T_PLL  = 1500;
    localparam int CMAX   = 65535;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idle = 1'b0, bank = 1'b0, dll_stop = 1'b0, reg_off = 1'b0, wake = 1'b0;
    logic [CNT_W-1:0] pd_lim = 16'd4, sr_lim = 16'd30;
    logic cke, dll_off, term_off, pll_off, ready;
    logic [3:0] state;

    int checks = 0, errors = 0;
    bit started = 0, done = 0;
    int m_st = 0, m_idle = 0, m_rem = 0;

    always #2 clk = ~clk;

    dram_lp_ctrl #(
        .CNT_W(CNT_W), .XP_CYC(T_XP), .XPDLL_CYC(T_XPD), .MRD_CYC(T_MRD),
        .SR_EXIT_CYC(T_SR), .PLL_RELOCK_CYC(T_PLL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .idle_i(idle), .bank_open_i(bank),
        .dll_stop_i(dll_stop), .reg_off_i(reg_off), .wake_i(wake),
        .pd_idle_lim_i(pd_lim), .sr_idle_lim_i(sr_lim),
        .cke_o(cke), .dll_off_o(dll_off), .term_off_o(term_off),
        .pll_off_o(pll_off), .ready_o(ready), .state_o(state)
    );

    function automatic int lat_of(int s);
        case (s)
            2, 3:    return T_XP;
            4:       return T_XPD;
            5:       return T_MRD + T_XPD;
            6:       return T_SR;
            7:       return T_SR + T_PLL;
            default: return 1;
        endcase
    endfunction

    function automatic int stby_of();
        return bank ? 1 : 0;
    endfunction

    // Behavioural reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_idle = 0; m_rem = 0;
        end else if (m_st <= 1) begin
            if (idle && !wake) begin
                if (m_idle < CMAX) m_idle = m_idle + 1;
                if (m_idle >= int'(pd_lim))
                    m_st = bank ? 2 : (!dll_stop ? 3 : (reg_off ? 5 : 4));
                else
                    m_st = stby_of();
            end else begin
                m_idle = 0;
                m_st = stby_of();
            end
        end else if (m_st <= 7) begin
            if (wake) begin
                m_rem = lat_of(m_st); m_st = 8; m_idle = 0;
            end else begin
                if (m_idle < CMAX) m_idle = m_idle + 1;
                if (m_st >= 3 && m_st <= 5 && m_idle >= int'(sr_lim))
                    m_st = reg_off ? 7 : 6;
            end
        end else begin
            m_idle = 0;
            m_rem = m_rem - 1;
            if (m_rem == 0) m_st = stby_of();
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            string sreq;
            bit e_cke, e_rdy, e_dll, e_term, e_pll;
            sreq   = (m_st <= 1) ? "R1" : (m_st <= 5) ? "R3" : (m_st <= 7) ? "R4" : "R8";
            e_cke  = (m_st <= 1) || (m_st == 8);
            e_rdy  = (m_st <= 1);
            e_dll  = (m_st >= 4) && (m_st <= 7);
            e_term = (m_st == 5) || (m_st == 7);
            e_pll  = (m_st == 7);
            check(int'(state) == m_st, sreq, "state", int'(state), m_st);
            check(cke == e_cke && ready == e_rdy, "R5", "cke/ready",
                  {cke, ready}, {e_cke, e_rdy});
            check(dll_off == e_dll && term_off == e_term && pll_off == e_pll, "R6",
                  "dll/term/pll", {dll_off, term_off, pll_off}, {e_dll, e_term, e_pll});
        end
    end

    // Wake from the current sleep state and count edges until ready (R8, R9)
    task automatic measure_exit(int exp_lat, string req, bit poke);
        int n;
        idle = 1'b0;
        wake = 1'b1;
        @(negedge clk);
        check(int'(state) == 8 && cke == 1'b1, "R7", "enter EXIT", int'(state), 8);
        n = 0;
        while (!ready && n < 5000) begin
            wake = poke && (n % 3 == 1);
            @(negedge clk);
            n++;
        end
        wake = 1'b0;
        check(n == exp_lat, req, "exit edges", n, exp_lat);
    endtask

    task automatic go_idle(int cycles);
        idle = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        started = 1;
        check(int'(state) == 0 && cke && ready, "R1", "reset state", int'(state), 0);

        bank = 1'b1; @(negedge clk);
        check(int'(state) == 1, "R1", "active standby", int'(state), 1);
        bank = 1'b0; @(negedge clk);
        check(int'(state) == 0, "R1", "precharge standby", int'(state), 0);

        // R2: interrupted idle run restarts the count
        go_idle(3); idle = 1'b0; @(negedge clk);
        go_idle(3);
        check(int'(state) == 0, "R2", "no entry before limit", int'(state), 0);
        @(negedge clk);
        check(int'(state) == 3 && dll_off == 1'b0, "R3", "fast power-down", int'(state), 3);
        measure_exit(T_XP, "R8", 0);

        // R3/R4: active power-down, never self-refresh
        bank = 1'b1;
        go_idle(4);
        check(int'(state) == 2 && !cke, "R3", "active power-down", int'(state), 2);
        go_idle(40);
        check(int'(state) == 2, "R4", "no self-refresh from active pd", int'(state), 2);
        measure_exit(T_XP, "R8", 0);
        check(int'(state) == 1 && ready, "R8", "return to active standby", int'(state), 1);
        bank = 1'b0; @(negedge clk);

        // Slow power-down, then register-off slow power-down
        dll_stop = 1'b1; reg_off = 1'b0;
        go_idle(4);
        check(int'(state) == 4 && dll_off && !term_off, "R6", "slow pd controls", int'(state), 4);
        measure_exit(T_XPD, "R8", 0);
        reg_off = 1'b1;
        go_idle(4);
        check(int'(state) == 5 && term_off && !pll_off, "R6", "slow pd reg-off", int'(state), 5);
        measure_exit(T_MRD + T_XPD, "R8", 0);

        // Self-refresh, wake pulses during exit are ignored
        dll_stop = 1'b0; reg_off = 1'b0;
        go_idle(30);
        check(int'(state) == 6 && dll_off && !pll_off, "R4", "self-refresh", int'(state), 6);
        measure_exit(T_SR, "R9", 1);

        // Register-off self-refresh
        dll_stop = 1'b1; reg_off = 1'b1;
        go_idle(30);
        check(int'(state) == 7 && pll_off && !cke, "R4", "self-refresh reg-off", int'(state), 7);
        measure_exit(T_SR + T_PLL, "R8", 0);

        // Zero limit behaves like one
        dll_stop = 1'b0; reg_off = 1'b0; pd_lim = '0;
        go_idle(1);
        check(int'(state) == 3, "R2", "zero limit", int'(state), 3);
        measure_exit(T_XP, "R8", 0);

        // Wake in standby blocks idle counting
        pd_lim = 16'd4;
        wake = 1'b1; go_idle(10);
        check(int'(state) == 0 && ready, "R2", "wake blocks entry", int'(state), 0);
        wake = 1'b0; idle = 1'b0;
        repeat (2) @(negedge clk);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule